// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

A peripheral arithmetic unit on a narrow register bus. Software loads two operand registers. The unit counts the operand writes, and once enough have arrived it performs a 16x16 multiply in a single cycle. The result goes to a read-only product register and to a 48-bit accumulator. A control register selects the operation and the signedness, and it also holds a sticky overflow flag.

The unit supports five operations: multiply, multiply-accumulate, multiply-subtract, multiply-negate and square. All of them except negate can be signed or unsigned; negate is always signed. The trigger needs either two operand writes or one. Square mode always triggers on a single write. Any write to the control register restarts the operand count. A write to the control register can also wipe the operands and the accumulator.

Top module: `mac_unit`

## Requirements
- R1: After reset, every readable register (addresses 0..7) reads zero.
- R2: Register map: 0 = operand A, 1 = operand B, 2 = control, 3/4 = product low/high, 5/6/7 = accumulator bits [15:0]/[31:16]/[47:32]. Operand and accumulator slices read back the value written.
- R3: The count select is control bit 4. With bit 4 = 0, the unit triggers when both A and B have been written since the last trigger or control write, in either order. A second write to the same operand does not advance the count. The result is readable one clock after the completing write.
- R4: With bit 4 = 1, every operand write triggers, using the current contents of both operands.
- R5: With control bit 3 = 1 (square), every operand write triggers regardless of bit 4, and the written operand is multiplied by itself.
- R6: Control bit 0 selects signed (1) or unsigned (0) operands. The product and its 48-bit extension follow this setting.
- R7: With bit 2 = 0 and bit 1 = 0 (multiply), the product register holds the 32-bit product and the accumulator is loaded with the extended product. Writes to addresses 3 and 4 are ignored.
- R8: With bit 2 = 1 and bit 1 = 0, the extended product is added to the accumulator.
- R9: With bit 2 = 1 and bit 1 = 1, the extended product is subtracted from the accumulator.
- R10: With bit 2 = 0 and bit 1 = 1 (negate), the signed product is negated and the result is written to both the product register and the accumulator. Bit 0 is ignored in this mode.
- R11: Control bit 6 is a read-only overflow flag. It sets when an accumulate or subtract leaves the 48-bit range for the selected signedness. It stays set until the next control write, which clears it.
- R12: A control write discards any partial operand count.
- R13: Control bit 5 (clear) reads back as 0. When it is written as 1, operands A and B and the accumulator become zero and the other control bits still take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |

## Verification
A wrong operand count shows up at the ports as a product register that changes one write too early or not at all. This is visible on the read one clock after the operand write that should, or should not, have completed the count. A bad extension or accumulate path shows up in the upper accumulator slice at the same read, because a sign error corrupts bits 47:32 first. A stale overflow flag is visible in the next control readback, and a missed clear is visible in the next operand or accumulator readback.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_OPA  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_OPB  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PRL  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_PRH  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_AC0  = 3'd5;
  localparam int unsigned CTRL_W  = 5;
  localparam int unsigned CLR_BIT = 5;
  localparam int unsigned OVF_BIT = 6;

  typedef struct packed {
    logic one_op;  // [4]
    logic sq;      // [3]
    logic acc;     // [2]
    logic sub;     // [1]
    logic sgn;     // [0]
  } ctrl_t;
endpackage

// File: rtl/mac_trigger.sv
module mac_trigger (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_a_i,
  input  logic       wr_b_i,
  input  logic       ctrl_wr_i,
  input  logic       single_i,
  output logic       fire_o,
  output logic [1:0] seen_o
);
  logic seen_a_q, seen_b_q;

  assign fire_o = (wr_a_i | wr_b_i) &
                  (single_i | (wr_a_i & seen_b_q) | (wr_b_i & seen_a_q));
  assign seen_o = {seen_b_q, seen_a_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (ctrl_wr_i || fire_o) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else begin
      if (wr_a_i) seen_a_q <= 1'b1;
      if (wr_b_i) seen_b_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int unsigned OP_W = 16,
  localparam int unsigned PROD_W = 2 * OP_W,
  localparam int unsigned ACC_W  = 3 * OP_W
) (
  input  logic [OP_W-1:0]   opa_i,
  input  logic [OP_W-1:0]   opb_i,
  input  logic              sq_i,
  input  logic              sq_use_b_i,
  input  logic              sgn_i,
  input  logic              acc_i,
  input  logic              sub_i,
  input  logic [ACC_W-1:0]  acc_q_i,
  output logic [PROD_W-1:0] prod_o,
  output logic [ACC_W-1:0]  acc_o,
  output logic              ovf_o
);
  logic              neg, sgn;
  logic [OP_W-1:0]   x, y;
  logic [PROD_W-1:0] xe, ye, raw;
  logic [ACC_W-1:0]  ext, negx;
  logic [ACC_W:0]    res;
  logic              ovf_s;

  assign neg = ~acc_i & sub_i;
  assign sgn = sgn_i | neg;
  assign x   = sq_i ? (sq_use_b_i ? opb_i : opa_i) : opa_i;
  assign y   = sq_i ? x : opb_i;
  assign xe  = sgn ? {{OP_W{x[OP_W-1]}}, x} : {{OP_W{1'b0}}, x};
  assign ye  = sgn ? {{OP_W{y[OP_W-1]}}, y} : {{OP_W{1'b0}}, y};
  assign raw = xe * ye;  // low half is exact for both signednesses
  assign ext = sgn ? {{OP_W{raw[PROD_W-1]}}, raw} : {{OP_W{1'b0}}, raw};
  assign negx = -ext;
  assign res = sub_i ? ({1'b0, acc_q_i} - {1'b0, ext}) : ({1'b0, acc_q_i} + {1'b0, ext});

  always_comb begin
    if (sub_i)
      ovf_s = (acc_q_i[ACC_W-1] != ext[ACC_W-1]) && (res[ACC_W-1] != acc_q_i[ACC_W-1]);
    else
      ovf_s = (acc_q_i[ACC_W-1] == ext[ACC_W-1]) && (res[ACC_W-1] != acc_q_i[ACC_W-1]);
  end

  always_comb begin
    ovf_o = 1'b0;
    if (acc_i) begin
      prod_o = raw;
      acc_o  = res[ACC_W-1:0];
      ovf_o  = sgn ? ovf_s : res[ACC_W];
    end else if (neg) begin
      prod_o = negx[PROD_W-1:0];
      acc_o  = negx;
    end else begin
      prod_o = raw;
      acc_o  = ext;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned OP_W = 16,
  localparam int unsigned PROD_W = 2 * OP_W,
  localparam int unsigned ACC_W  = 3 * OP_W,
  localparam int unsigned N_SLC  = ACC_W / OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OP_W-1:0]   wdata_i,
  output logic [OP_W-1:0]   rdata_o
);
  logic [OP_W-1:0]   opa_q, opb_q;
  ctrl_t             ctrl_q;
  logic              ovf_q, exec_q, sq_b_q;
  logic [PROD_W-1:0] prod_q, dp_prod;
  logic [ACC_W-1:0]  acc_q, dp_acc;
  logic              dp_ovf, fire;
  logic [1:0]        seen;
  logic              wr_a, wr_b, ctrl_wr, clr;
  logic [N_SLC-1:0]  slc_wr;

  assign wr_a    = we_i && addr_i == ADR_OPA;
  assign wr_b    = we_i && addr_i == ADR_OPB;
  assign ctrl_wr = we_i && addr_i == ADR_CTRL;
  assign clr     = ctrl_wr && wdata_i[CLR_BIT];

  for (genvar g = 0; g < N_SLC; g++) begin : g_slc
    assign slc_wr[g] = we_i && addr_i == ADR_AC0 + ADDR_W'(g);
  end

  mac_trigger trig_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_a_i    (wr_a),
    .wr_b_i    (wr_b),
    .ctrl_wr_i (ctrl_wr),
    .single_i  (ctrl_q.one_op | ctrl_q.sq),
    .fire_o    (fire),
    .seen_o    (seen)
  );

  mac_datapath #(.OP_W(OP_W)) dp_i (
    .opa_i      (opa_q),
    .opb_i      (opb_q),
    .sq_i       (ctrl_q.sq),
    .sq_use_b_i (sq_b_q),
    .sgn_i      (ctrl_q.sgn),
    .acc_i      (ctrl_q.acc),
    .sub_i      (ctrl_q.sub),
    .acc_q_i    (acc_q),
    .prod_o     (dp_prod),
    .acc_o      (dp_acc),
    .ovf_o      (dp_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q  <= '0;
      opb_q  <= '0;
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      exec_q <= 1'b0;
      sq_b_q <= 1'b0;
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      exec_q <= fire;
      if (fire) sq_b_q <= wr_b;
      if (clr) begin
        opa_q <= '0;
        opb_q <= '0;
      end else begin
        if (wr_a) opa_q <= wdata_i;
        if (wr_b) opb_q <= wdata_i;
      end
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      // control write wins over a same-edge overflow
      if (ctrl_wr) ovf_q <= 1'b0;
      else if (exec_q && dp_ovf) ovf_q <= 1'b1;
      if (exec_q) prod_q <= dp_prod;
      if (clr) acc_q <= '0;
      else if (exec_q) acc_q <= dp_acc;
      else begin
        for (int i = 0; i < N_SLC; i++)
          if (slc_wr[i]) acc_q[i*OP_W +: OP_W] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_OPA:  rdata_o = opa_q;
      ADR_OPB:  rdata_o = opb_q;
      ADR_CTRL: begin
        rdata_o[CTRL_W-1:0] = ctrl_q;
        rdata_o[OVF_BIT]    = ovf_q;
      end
      ADR_PRL:  rdata_o = prod_q[OP_W-1:0];
      ADR_PRH:  rdata_o = prod_q[PROD_W-1:OP_W];
      default: begin
        for (int i = 0; i < N_SLC; i++)
          if (addr_i == ADR_AC0 + ADDR_W'(i)) rdata_o = acc_q[i*OP_W +: OP_W];
      end
    endcase
  end
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
#(
  parameter int unsigned OP_W = 16,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [OP_W-1:0]   wdata_i,
  input logic [OP_W-1:0]   rdata_o,
  input logic [1:0]        seen_i,
  input logic              exec_i,
  input logic              ovf_i,
  input logic [OP_W-1:0]   opa_i,
  input logic [PROD_W-1:0] prod_i
);
  // R13
  clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADR_CTRL |-> !rdata_o[CLR_BIT]);

  // R12
  count_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_CTRL) |=> seen_i == 2'b00);

  // R11
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_CTRL) |=> !ovf_i);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !(we_i && addr_i == ADR_CTRL)) |=> ovf_i);

  // R7
  prod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(prod_i));

  // R2
  opa_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == ADR_OPA || addr_i == ADR_CTRL)) |=> $stable(opa_i));
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .seen_i  (seen),
  .exec_i  (exec_q),
  .ovf_i   (ovf_q),
  .opa_i   (opa_q),
  .prod_i  (prod_q)
);

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [15:0] wdata_i = 16'd0;
  logic [15:0] rdata_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  mac_unit dut_i (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk_i);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic rd_prod(output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(3'd3, lo); rd(3'd4, hi);
    v = {hi, lo};
  endtask

  task automatic rd_acc(output logic [47:0] v);
    logic [15:0] s0, s1, s2;
    rd(3'd5, s0); rd(3'd6, s1); rd(3'd7, s2);
    v = {s2, s1, s0};
  endtask

  task automatic set_acc(input logic [47:0] v);
    wr(3'd5, v[15:0]); wr(3'd6, v[31:16]); wr(3'd7, v[47:32]);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk("R1 reset value", 64'(v), 64'd0);
    end
  endtask

  task automatic t_two_op;
    logic [15:0] v; logic [31:0] p; logic [47:0] a;
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h1234);
    rd(3'd0, v); chk("R2 opa readback", 64'(v), 64'h1234);
    rd_prod(p); chk("R3 no trigger on one write", 64'(p), 64'd0);
    wr(3'd0, 16'h0003);
    rd_prod(p); chk("R3 repeat write no trigger", 64'(p), 64'd0);
    wr(3'd1, 16'h0005);
    rd_prod(p); chk("R3 A then B", 64'(p), 64'd15);
    rd_acc(a); chk("R7 mul loads acc", 64'(a), 64'd15);
    rd(3'd1, v); chk("R2 opb readback", 64'(v), 64'h5);
    wr(3'd1, 16'd7); wr(3'd0, 16'd9);
    rd_prod(p); chk("R3 B then A", 64'(p), 64'd63);
    wr(3'd3, 16'hAAAA); wr(3'd4, 16'h5555);
    rd_prod(p); chk("R7 product read-only", 64'(p), 64'd63);
  endtask

  task automatic t_sign;
    logic [31:0] p; logic [47:0] a;
    wr(3'd2, 16'h0001);
    wr(3'd0, 16'hFFFE); wr(3'd1, 16'h0003);
    rd_prod(p); chk("R6 signed product", 64'(p), 64'hFFFF_FFFA);
    rd_acc(a); chk("R6 signed extension", 64'(a), 64'hFFFF_FFFF_FFFA);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'hFFFE); wr(3'd1, 16'h0003);
    rd_prod(p); chk("R6 unsigned product", 64'(p), 64'h0002_FFFA);
    rd_acc(a); chk("R6 unsigned extension", 64'(a), 64'h0002_FFFA);
  endtask

  task automatic t_single;
    logic [31:0] p;
    wr(3'd2, 16'h0010);
    wr(3'd0, 16'd2);
    rd_prod(p); chk("R4 single write on A", 64'(p), 64'd6);
    wr(3'd1, 16'd10);
    rd_prod(p); chk("R4 single write on B", 64'(p), 64'd20);
  endtask

  task automatic t_square;
    logic [31:0] p;
    wr(3'd2, 16'h0008);
    wr(3'd1, 16'h0100);
    rd_prod(p); chk("R5 square of B", 64'(p), 64'h0001_0000);
    wr(3'd2, 16'h0009);
    wr(3'd0, 16'hFFFF);
    rd_prod(p); chk("R5 signed square of A", 64'(p), 64'd1);
    wr(3'd2, 16'h0008);
    wr(3'd0, 16'hFFFF);
    rd_prod(p); chk("R5 unsigned square of A", 64'(p), 64'hFFFE_0001);
  endtask

  task automatic t_acc_sub;
    logic [31:0] p; logic [47:0] a;
    wr(3'd2, 16'h0004);
    set_acc(48'h10);
    wr(3'd0, 16'd4); wr(3'd1, 16'd5);
    rd_prod(p); chk("R8 product raw in acc mode", 64'(p), 64'd20);
    rd_acc(a); chk("R8 accumulate", 64'(a), 64'h24);
    wr(3'd0, 16'd2); wr(3'd1, 16'd3);
    rd_acc(a); chk("R8 accumulate again", 64'(a), 64'h2A);
    wr(3'd2, 16'h0007);
    wr(3'd0, 16'hFFFF); wr(3'd1, 16'd2);
    rd_prod(p); chk("R9 product raw in sub mode", 64'(p), 64'hFFFF_FFFE);
    rd_acc(a); chk("R9 subtract signed", 64'(a), 64'h2C);
  endtask

  task automatic t_neg;
    logic [31:0] p; logic [47:0] a;
    wr(3'd2, 16'h0002);
    wr(3'd0, 16'hFFFF); wr(3'd1, 16'd3);
    rd_prod(p); chk("R10 negate forced signed", 64'(p), 64'd3);
    rd_acc(a); chk("R10 negate to acc", 64'(a), 64'd3);
    wr(3'd0, 16'd5); wr(3'd1, 16'd6);
    rd_prod(p); chk("R10 negate product", 64'(p), 64'hFFFF_FFE2);
    rd_acc(a); chk("R10 negate acc", 64'(a), 64'hFFFF_FFFF_FFE2);
  endtask

  task automatic t_ovf;
    logic [15:0] v; logic [47:0] a;
    wr(3'd2, 16'h0004);
    set_acc(48'hFFFF_FFFF_FFFF);
    wr(3'd0, 16'd1); wr(3'd1, 16'd1);
    rd_acc(a); chk("R11 unsigned wrap", 64'(a), 64'd0);
    rd(3'd2, v); chk("R11 unsigned overflow flag", 64'(v), 64'h44);
    wr(3'd0, 16'd1); wr(3'd1, 16'd1);
    rd(3'd2, v); chk("R11 flag sticky", 64'(v), 64'h44);
    wr(3'd2, 16'h0004);
    rd(3'd2, v); chk("R11 flag cleared by control write", 64'(v), 64'h04);
    wr(3'd2, 16'h0005);
    set_acc(48'h7FFF_FFFF_FFFF);
    wr(3'd0, 16'd1); wr(3'd1, 16'd1);
    rd_acc(a); chk("R11 signed wrap", 64'(a), 64'h8000_0000_0000);
    rd(3'd2, v); chk("R11 signed overflow flag", 64'(v), 64'h45);
    wr(3'd0, 16'd1); wr(3'd1, 16'hFFFF);
    rd(3'd2, v); chk("R11 signed flag held", 64'(v), 64'h45);
  endtask

  task automatic t_count_reset;
    logic [31:0] p;
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'd6); wr(3'd1, 16'd6);
    rd_prod(p); chk("R12 baseline", 64'(p), 64'd36);
    wr(3'd0, 16'd6);
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'd7);
    rd_prod(p); chk("R12 count flushed by control write", 64'(p), 64'd36);
    wr(3'd0, 16'd6);
    rd_prod(p); chk("R12 fresh count triggers", 64'(p), 64'd42);
  endtask

  task automatic t_clear;
    logic [15:0] v; logic [31:0] p; logic [47:0] a;
    wr(3'd2, 16'h0021);
    rd(3'd2, v); chk("R13 clear bit reads zero", 64'(v), 64'h01);
    rd(3'd0, v); chk("R13 opa cleared", 64'(v), 64'd0);
    rd(3'd1, v); chk("R13 opb cleared", 64'(v), 64'd0);
    rd_acc(a); chk("R13 acc cleared", 64'(a), 64'd0);
    rd_prod(p); chk("R13 product kept", 64'(p), 64'd42);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_two_op();
    t_sign();
    t_single();
    t_square();
    t_acc_sub();
    t_neg();
    t_ovf();
    t_count_reset();
    t_clear();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule